// File: doc/BRIEF.md
# Compact Genetic Search Cell

This block runs a compact genetic search over an L-bit chromosome. It does not hold a population. Instead it keeps one 8-bit probability entry per bit. Each round it draws two candidate strings from those entries and scores each one with a built-in fitness function, the number of ones. It then nudges every entry toward the fitter string. A round takes four clock cycles. Rounds repeat after a `start` pulse until every entry has saturated, and then the cell goes idle with `converged` high.

Each time a round changes the vector, a confidence counter advances. A snapshot of the vector and the counter is then offered to a group leader on a valid/ready output. A stalled snapshot blocks the next vector-changing commit until it is accepted: the offer holds its data while `ldr_out_ready` is low, and the search loop waits in its update step rather than drop a snapshot. The leader can also write a full replacement vector through a valid/ready input. That input is ready while the cell is idle and in the first step of every round.

Top module: `cga_cell`

## Requirements
- R1: After reset the vector holds INIT (128) in every entry, `ldr_out_conf` is 0, `ldr_out_vec` shows the INIT vector, `ldr_out_valid` and `converged` are low, `solution` is 0 and `ldr_in_ready` is high (idle).
- R2: Bit i has its own 8-bit generator with seed ((SEED + 29*i) mod 255) + 1. Each step maps state s to {s[6:0], s[7]^s[5]^s[4]^s[3]}. A drawn bit is 1 when the generator's current value is less than or equal to entry i, and the generator then steps once. Candidate A is drawn first and candidate B second, one per cycle.
- R3: The candidate with more ones wins. On a tie candidate A wins.
- R4: At each position where winner and loser differ, the entry moves by STEP (16) toward the winner's bit, clamped to 0..255. All other entries keep their value. Entry i sits at bits [8i+7:8i] of every vector port.
- R5: Each round that changes at least one entry raises the confidence counter by one and offers the new vector with the new count on the leader output. A round that changes nothing offers nothing.
- R6: While `ldr_out_valid` is high and `ldr_out_ready` is low, the offer and its data stay unchanged. A later changing commit waits until the pending offer is taken.
- R7: Without back-pressure one round takes exactly four clock cycles, so consecutive offers are four cycles apart per round.
- R8: The cell checks the vector after every round. When every entry is 0 or 255 it stops and shows `converged` high, with `solution[i]` = 1 exactly where entry i is 255. The flag also follows a vector written by the leader.
- R9: A leader write accepted while idle or in the first step of a round replaces the whole vector. In a round it restarts sampling from the new vector, and the generators do not step on that cycle.
- R10: `start` has no effect while a search is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a search when idle |
| ldr_out_valid | output | 1 | Snapshot offered to the leader |
| ldr_out_ready | input | 1 | Leader takes the snapshot |
| ldr_out_vec | output | L*8 | Snapshot of the probability vector |
| ldr_out_conf | output | CW | Snapshot of the confidence counter |
| ldr_in_valid | input | 1 | Leader offers a replacement vector |
| ldr_in_ready | output | 1 | Cell can accept a replacement now |
| ldr_in_vec | input | L*8 | Replacement probability vector |
| converged | output | 1 | Every entry is saturated |
| solution | output | L | Bits whose entry is 255 |

## Verification
The hardest state to reach from the ports is a leader write that lands in the middle of a search: the write is taken only in the first step of a round, and rounds run on their own. The stimulus raises the write request during a run and holds it until the ready signal shows. The written vector is all-saturated, so the result is fixed whatever the timing: one unchanged round, then idle with every solution bit set. Back-pressure during a long search is the other awkward case. It is produced by a ready pattern that is low two cycles in three, so several commits find an offer still pending.

// File: rtl/cga_pkg.sv
package cga_pkg;
  localparam int PW = 8;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SA,
    ST_SB,
    ST_CMP,
    ST_UPD
  } cga_state_e;
endpackage

// File: rtl/cga_lfsr.sv
module cga_lfsr #(
  parameter logic [7:0] SEED = 8'd1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       adv,
  output logic [7:0] val
);
  always_ff @(posedge clk) begin
    if (!rst_n) val <= SEED;
    else if (adv) val <= {val[6:0], val[7] ^ val[5] ^ val[4] ^ val[3]};
  end
endmodule

// File: rtl/cga_entry.sv
module cga_entry #(
  parameter int PW   = 8,
  parameter int STEP = 16
) (
  input  logic [PW-1:0] p,
  input  logic          win,
  input  logic          lose,
  output logic [PW-1:0] p_next,
  output logic          chg
);
  localparam logic [PW:0]   PMAX = (PW+1)'((1 << PW) - 1);
  localparam logic [PW-1:0] STP  = PW'(STEP);
  logic [PW:0] up;

  always_comb begin
    chg = win ^ lose;
    up  = {1'b0, p} + {1'b0, STP};
    if (!chg) p_next = p;
    else if (win) p_next = (up > PMAX) ? PMAX[PW-1:0] : up[PW-1:0];
    else p_next = (p < STP) ? '0 : p - STP;
  end
endmodule

// File: rtl/cga_judge.sv
module cga_judge #(
  parameter int L = 8
) (
  input  logic [L-1:0] a,
  input  logic [L-1:0] b,
  output logic [L-1:0] win,
  output logic [L-1:0] lose
);
  localparam int CNTW = $clog2(L + 1);
  logic [CNTW-1:0] ca, cb;

  always_comb begin
    ca = '0;
    cb = '0;
    for (int i = 0; i < L; i++) begin
      ca = ca + CNTW'(a[i]);
      cb = cb + CNTW'(b[i]);
    end
    if (ca >= cb) begin
      win  = a;
      lose = b;
    end else begin
      win  = b;
      lose = a;
    end
  end
endmodule

// File: rtl/cga_cell.sv
module cga_cell
  import cga_pkg::*;
#(
  parameter int L    = 8,
  parameter int STEP = 16,
  parameter int INIT = 128,
  parameter int CW   = 16,
  parameter int SEED = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  output logic            ldr_out_valid,
  input  logic            ldr_out_ready,
  output logic [L*PW-1:0] ldr_out_vec,
  output logic [CW-1:0]   ldr_out_conf,
  input  logic            ldr_in_valid,
  output logic            ldr_in_ready,
  input  logic [L*PW-1:0] ldr_in_vec,
  output logic            converged,
  output logic [L-1:0]    solution
);
  localparam logic [PW-1:0] INIT_V = PW'(INIT);

  cga_state_e          st;
  logic [L-1:0][PW-1:0] prob_q, p_nxt, rnd;
  logic [L-1:0]        draw, samp_a, samp_b, win_c, lose_c, win_q, lose_q;
  logic [L-1:0]        chg, extreme, ext_nxt;
  logic                any_chg, load_acc, stall, commit;

  assign ldr_in_ready = (st == ST_IDLE) || (st == ST_SA);
  assign load_acc     = ldr_in_valid && ldr_in_ready;
  assign any_chg      = |chg;
  assign stall        = (st == ST_UPD) && any_chg && ldr_out_valid && !ldr_out_ready;
  assign commit       = (st == ST_UPD) && !stall;
  assign converged    = &extreme;

  for (genvar i = 0; i < L; i++) begin : g_bit
    localparam logic [7:0] SD = 8'(((SEED + i * 29) % 255) + 1);
    logic adv;
    assign adv = ((st == ST_SA) && !ldr_in_valid) || (st == ST_SB);

    cga_lfsr #(.SEED(SD)) u_rng (
      .clk  (clk),
      .rst_n(rst_n),
      .adv  (adv),
      .val  (rnd[i])
    );

    cga_entry #(.PW(PW), .STEP(STEP)) u_ent (
      .p     (prob_q[i]),
      .win   (win_q[i]),
      .lose  (lose_q[i]),
      .p_next(p_nxt[i]),
      .chg   (chg[i])
    );

    assign draw[i]     = rnd[i] <= prob_q[i];
    assign extreme[i]  = (prob_q[i] == '0) || (&prob_q[i]);
    assign ext_nxt[i]  = (p_nxt[i] == '0) || (&p_nxt[i]);
    assign solution[i] = &prob_q[i];
  end

  cga_judge #(.L(L)) u_judge (
    .a   (samp_a),
    .b   (samp_b),
    .win (win_c),
    .lose(lose_c)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      prob_q <= {L{INIT_V}};
      samp_a <= '0;
      samp_b <= '0;
      win_q  <= '0;
      lose_q <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (load_acc) prob_q <= ldr_in_vec;
          if (start) st <= ST_SA;
        end
        ST_SA: begin
          if (load_acc) prob_q <= ldr_in_vec;
          else begin
            samp_a <= draw;
            st     <= ST_SB;
          end
        end
        ST_SB: begin
          samp_b <= draw;
          st     <= ST_CMP;
        end
        ST_CMP: begin
          win_q  <= win_c;
          lose_q <= lose_c;
          st     <= ST_UPD;
        end
        ST_UPD: begin
          if (commit) begin
            prob_q <= p_nxt;
            st     <= (&ext_nxt) ? ST_IDLE : ST_SA;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ldr_out_valid <= 1'b0;
      ldr_out_vec   <= {L{INIT_V}};
      ldr_out_conf  <= '0;
    end else begin
      if (ldr_out_valid && ldr_out_ready) ldr_out_valid <= 1'b0;
      if (commit && any_chg) begin
        ldr_out_valid <= 1'b1;
        ldr_out_vec   <= p_nxt;
        ldr_out_conf  <= ldr_out_conf + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cga_cell_chk.sv
module cga_cell_chk #(
  parameter int L  = 8,
  parameter int CW = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            ldr_out_valid,
  input logic            ldr_out_ready,
  input logic [L*8-1:0]  ldr_out_vec,
  input logic [CW-1:0]   ldr_out_conf,
  input logic            ldr_in_valid,
  input logic            ldr_in_ready,
  input logic [L-1:0]    solution
);
  a_r6_offer_held: assert property (@(posedge clk) disable iff (!rst_n)
    ldr_out_valid && !ldr_out_ready |=>
      ldr_out_valid && $stable(ldr_out_vec) && $stable(ldr_out_conf));

  a_r5_conf_step: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ldr_out_conf) |-> ldr_out_conf == CW'($past(ldr_out_conf) + 1'b1));

  a_r5_conf_offered: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ldr_out_conf) |-> ldr_out_valid);

  a_r9_vector_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ldr_in_ready && !ldr_in_valid && !start |=> $stable(solution));
endmodule

bind cga_cell cga_cell_chk #(.L(L), .CW(CW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start        (start),
  .ldr_out_valid(ldr_out_valid),
  .ldr_out_ready(ldr_out_ready),
  .ldr_out_vec  (ldr_out_vec),
  .ldr_out_conf (ldr_out_conf),
  .ldr_in_valid (ldr_in_valid),
  .ldr_in_ready (ldr_in_ready),
  .solution     (solution)
);

// File: tb/cga_cell_tb.sv
`timescale 1ns/1ps
module cga_cell_tb;
  localparam int L = 8, STEP = 16, INIT = 128, CW = 16, SEED = 1;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic ldr_out_valid, ldr_out_ready = 1'b1, ldr_in_valid = 1'b0, ldr_in_ready, converged;
  logic [L*8-1:0] ldr_out_vec, ldr_in_vec = '0;
  logic [CW-1:0] ldr_out_conf;
  logic [L-1:0] solution;

  cga_cell #(.L(L), .STEP(STEP), .INIT(INIT), .CW(CW), .SEED(SEED)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .ldr_out_valid(ldr_out_valid), .ldr_out_ready(ldr_out_ready),
    .ldr_out_vec(ldr_out_vec), .ldr_out_conf(ldr_out_conf),
    .ldr_in_valid(ldr_in_valid), .ldr_in_ready(ldr_in_ready), .ldr_in_vec(ldr_in_vec),
    .converged(converged), .solution(solution));

  always #5 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  bit mon_en = 0, tim_en = 0, bp_mode = 0, have_base = 0, hold_pend = 0, done = 0;
  int base_cyc, base_iter;
  logic [L*8-1:0] hold_vec;
  logic [CW-1:0] hold_conf;

  typedef struct { logic [L*8-1:0] vec; int conf; int iter; } push_t;
  push_t exp_q[$];
  int mp[L];
  logic [7:0] ml[L];
  int m_conf, m_iter;

  always @(posedge clk) cyc <= cyc + 1;
  always @(posedge clk) begin
    #1;
    ldr_out_ready <= bp_mode ? (cyc % 3 == 0) : 1'b1;
  end

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] lfsr_step(logic [7:0] s);
    return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
  endfunction

  function automatic logic [L*8-1:0] pack_mp();
    logic [L*8-1:0] v;
    for (int i = 0; i < L; i++) v[i*8 +: 8] = 8'(mp[i]);
    return v;
  endfunction

  function automatic logic [L-1:0] model_sol();
    logic [L-1:0] s;
    for (int i = 0; i < L; i++) s[i] = (mp[i] == 255);
    return s;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < L; i++) begin
      mp[i] = INIT;
      ml[i] = 8'(((SEED + i * 29) % 255) + 1);
    end
    m_conf = 0;
    m_iter = 0;
    exp_q.delete();
  endtask

  // driver side of the scoreboard: predicts every offer of one search
  task automatic predict_run();
    logic [L-1:0] a, b, w, lo;
    bit chg, conv;
    push_t p;
    for (int g = 0; g < 20000; g++) begin
      for (int i = 0; i < L; i++) begin a[i] = (ml[i] <= 8'(mp[i])); ml[i] = lfsr_step(ml[i]); end
      for (int i = 0; i < L; i++) begin b[i] = (ml[i] <= 8'(mp[i])); ml[i] = lfsr_step(ml[i]); end
      if ($countones(a) >= $countones(b)) begin w = a; lo = b; end
      else begin w = b; lo = a; end
      chg = 0;
      for (int i = 0; i < L; i++)
        if (w[i] != lo[i]) begin
          chg = 1;
          if (w[i]) mp[i] = (mp[i] + STEP > 255) ? 255 : mp[i] + STEP;
          else mp[i] = (mp[i] < STEP) ? 0 : mp[i] - STEP;
        end
      if (chg) begin
        m_conf++;
        p.vec = pack_mp(); p.conf = m_conf; p.iter = m_iter;
        exp_q.push_back(p);
      end
      m_iter++;
      conv = 1;
      for (int i = 0; i < L; i++) if (mp[i] != 0 && mp[i] != 255) conv = 0;
      if (conv) break;
    end
  endtask

  // monitor side of the scoreboard
  always @(negedge clk) begin
    push_t p;
    if (hold_pend) begin
      chk(ldr_out_valid, "R6", "offer dropped under back-pressure", 64'(ldr_out_valid), 64'd1);
      chk(ldr_out_vec == hold_vec && ldr_out_conf == hold_conf, "R6", "held data changed",
          64'(ldr_out_vec), 64'(hold_vec));
    end
    hold_pend = ldr_out_valid && !ldr_out_ready;
    hold_vec  = ldr_out_vec;
    hold_conf = ldr_out_conf;
    if (mon_en && ldr_out_valid && ldr_out_ready) begin
      if (exp_q.size() == 0) chk(0, "R5", "unexpected offer", 64'(ldr_out_conf), 64'd0);
      else begin
        p = exp_q.pop_front();
        chk(ldr_out_vec == p.vec, "R4", "offered vector", 64'(ldr_out_vec), 64'(p.vec));
        chk(int'(ldr_out_conf) == p.conf, "R5", "offered count", 64'(ldr_out_conf), 64'(p.conf));
        if (tim_en) begin
          if (have_base)
            chk(cyc - base_cyc == 4 * (p.iter - base_iter), "R7", "cycles between offers",
                64'(cyc - base_cyc), 64'(4 * (p.iter - base_iter)));
          else begin have_base = 1; base_cyc = cyc; base_iter = p.iter; end
        end
      end
    end
  end

  task automatic pulse_start();
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
  endtask

  task automatic leader_write(logic [L*8-1:0] v);
    @(posedge clk); #1;
    ldr_in_vec = v; ldr_in_valid = 1'b1;
    do @(negedge clk); while (!ldr_in_ready);
    @(posedge clk); #1 ldr_in_valid = 1'b0;
  endtask

  task automatic wait_done();
    repeat (10) @(posedge clk);
    while (!(converged && !ldr_out_valid)) @(posedge clk);
    repeat (2) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(posedge clk); #1 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    model_reset();
    @(negedge clk);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "R7", "watchdog expired", 64'(cyc), 64'd0);
    finish_up();
  end

  initial begin
    logic [L*8-1:0] v;
    do_reset();
    // R1 reset state
    chk(!ldr_out_valid, "R1", "valid after reset", 64'(ldr_out_valid), 64'd0);
    chk(ldr_out_conf == 0, "R1", "count after reset", 64'(ldr_out_conf), 64'd0);
    chk(ldr_out_vec == {L{8'(INIT)}}, "R1", "vector after reset", 64'(ldr_out_vec), 64'({L{8'(INIT)}}));
    chk(!converged && solution == 0, "R1", "converged/solution after reset", 64'({converged, solution}), 64'd0);
    chk(ldr_in_ready, "R1", "idle after reset", 64'(ldr_in_ready), 64'd1);

    // Search from reset, full scoreboard and round timing; a start mid-run (R10)
    predict_run();
    mon_en = 1; tim_en = 1; have_base = 0;
    pulse_start();
    repeat (37) @(posedge clk);
    pulse_start();
    wait_done();
    chk(exp_q.size() == 0, "R5", "offers outstanding after search (R2 R3 R10)", 64'(exp_q.size()), 64'd0);
    chk(converged, "R8", "converged at end", 64'(converged), 64'd1);
    chk(solution == model_sol(), "R8", "solution bits", 64'(solution), 64'(model_sol()));
    tim_en = 0;

    // Start while already converged: one quiet round, nothing offered
    predict_run();
    pulse_start();
    wait_done();
    chk(exp_q.size() == 0 && m_conf == int'(ldr_out_conf), "R5", "quiet round offered",
        64'(ldr_out_conf), 64'(m_conf));
    chk(solution == model_sol(), "R8", "solution after quiet round", 64'(solution), 64'(model_sol()));

    // Leader writes while idle
    for (int i = 0; i < L; i++) v[i*8 +: 8] = (i % 2 == 0) ? 8'd255 : 8'd0;
    leader_write(v);
    @(negedge clk);
    chk(converged, "R9", "saturated write sets converged", 64'(converged), 64'd1);
    chk(solution == 8'h55, "R8", "solution follows written vector", 64'(solution), 64'h55);
    for (int i = 0; i < L; i++) begin
      v[i*8 +: 8] = 8'(40 + 25 * i);
      mp[i] = 40 + 25 * i;
    end
    leader_write(v);
    @(negedge clk);
    chk(!converged && solution == 0, "R9", "mixed write clears converged",
        64'({converged, solution}), 64'd0);

    // Search from written vector under back-pressure (R6)
    predict_run();
    bp_mode = 1;
    pulse_start();
    wait_done();
    chk(exp_q.size() == 0, "R6", "offers outstanding under back-pressure", 64'(exp_q.size()), 64'd0);
    chk(solution == model_sol(), "R8", "solution after back-pressured search", 64'(solution), 64'(model_sol()));
    bp_mode = 0;

    // Leader write in the middle of a search (R9)
    mon_en = 0;
    do_reset();
    pulse_start();
    repeat (21) @(posedge clk);
    leader_write({L{8'hFF}});
    repeat (8) @(posedge clk);
    @(negedge clk);
    chk(converged, "R9", "mid-run write converged", 64'(converged), 64'd1);
    chk(solution == {L{1'b1}}, "R9", "mid-run write solution", 64'(solution), 64'({L{1'b1}}));
    chk(ldr_in_ready && !ldr_out_valid, "R9", "idle after mid-run write",
        64'({ldr_in_ready, ldr_out_valid}), 64'b10);
    finish_up();
  end
endmodule